// File: doc/BRIEF.md
# Reset-strapped debug test port

This block owns an 8-pin bidirectional test port. While system reset is held, the pins are left undriven so that board-level pulls (an on-pad pulldown by default, an optional pullup jumper) set their levels. On the first clock after reset is released, the block stores those levels as its test-mode word. From the following clock onward, it drives the pins as outputs.

The stored word stays fixed until reset is asserted again. Only its bit 0 selects the mode. When bit 0 is 0, the port is quiet: every pin is driven low, so the pads do not switch during normal operation. When bit 0 is 1, the port shows eight internal bus-handshake debug signals. Each signal passes through one register before it reaches its pin. A status output shows the stored word.

Top module: `strap_test_port`

## Requirements
- R1: While `rst_n` is low, `pad_oe`, `pad_out` and `mode_status` are all 8'h00. Asserting `rst_n` low clears them at once, without waiting for a clock edge.
- R2: At the first rising `clk` edge that sees `rst_n` high after it was low, the block stores `pad_in`. From that edge onward, `mode_status` equals the stored value.
- R3: Later changes on `pad_in`, including those caused by the block's own driven outputs, leave `mode_status` unchanged until the next reset.
- R4: With the pins held only by their pulldowns (level 0), the stored word is 8'h00 and the port is quiet.
- R5: When stored bit 0 is 0 (quiet mode), `pad_out` is 8'h00 on every clock, whatever the values of `dbg_in` and of the other stored bits.
- R6: When stored bit 0 is 1 (debug mode), `pad_out[i]` equals `dbg_in[i]` as sampled one clock edge earlier. The `dbg_in` bits, in order from bit 0 to bit 7, are:
  - bus ready
  - program-memory select
  - transfer-type bit 1
  - memory-controller ready out
  - external-memory request
  - external-memory request accept
  - external-memory access done
  - processor clock-gate
- R7: `pad_oe` stays 8'h00 through the storing edge. It becomes 8'hFF at the next edge and stays 8'hFF until reset.
- R8: Stored bits 7:1 have no effect on the mode. A stored word of 8'hFE gives quiet mode. Stored words of 8'h81 and 8'hFF give debug mode.
- R9: After a reset asserted in the middle of operation, the following release stores the new pin levels afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low; the rising transition triggers the store |
| pad_in | input | 8 | Levels read back from the test pins |
| dbg_in | input | 8 | Internal debug signals, bit order as in R6 |
| pad_out | output | 8 | Data driven to the test pins |
| pad_oe | output | 8 | Output enable per pin, 1 = drive |
| mode_status | output | 8 | Stored test-mode word |

## Verification
The bench models each pad: a pin reads the strap level while it is undriven and follows `pad_out` once enabled. Feedback through the pads could therefore corrupt the mode if the block kept sampling after the first edge, and the R3 checks would catch that.

Other corner cases are checked as follows:
- **Selection by bit 0 alone.** Straps 8'hFE, 8'h80 and 8'h81 are applied. A design that selected the mode from any other bit, or from the whole word, would choose the wrong mode.
- **Output-enable timing.** `pad_oe` is checked just after the storing edge. A design that enabled the outputs in that same cycle would fight the straps.
- **Debug latency.** Debug data is checked one edge after each change on `dbg_in`. A missing or doubled register would show old or early data.
- **Reset in mid-run.** A reset is asserted between clock edges. The bench checks that the clear happens without a clock and that the next release stores fresh values.

// File: rtl/strap_port_pkg.sv
package strap_port_pkg;

  typedef enum logic {
    MODE_QUIET  = 1'b0,
    MODE_BUSDBG = 1'b1
  } port_mode_e;

  // Mode is decided by the selector strap bit alone.
  function automatic port_mode_e decode_mode(input logic sel_bit);
    return sel_bit ? MODE_BUSDBG : MODE_QUIET;
  endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_port_pkg::*;
#(
  parameter int PINS    = 8,
  parameter int SEL_BIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] mode_word,
  output port_mode_e      mode,
  output logic            cap_done
);

  logic            released_q;
  logic [PINS-1:0] word_q;
  logic            capture_pulse;

  // High only during the first cycle after the reset release.
  assign capture_pulse = rst_n && !released_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      released_q <= 1'b0;
      word_q     <= '0;
    end else begin
      released_q <= 1'b1;
      if (capture_pulse) word_q <= pad_in;
    end
  end

  assign mode_word = word_q;
  assign cap_done  = released_q;
  assign mode      = decode_mode(word_q[SEL_BIT]);

  assert_capture_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capture_pulse |=> (mode_word == $past(pad_in)))
    else $error("strap word differs from sampled pins");

  assert_word_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> $stable(mode_word))
    else $error("strap word changed after capture");

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_word_cleared_R1: assert (mode_word == '0 && !cap_done)
        else $error("strap word not cleared in reset");
    end
  end

endmodule

// File: rtl/strap_out_stage.sv
module strap_out_stage
  import strap_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_done,
  input  port_mode_e      mode,
  input  logic [PINS-1:0] dbg_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);

  logic [PINS-1:0] data_q;
  logic [PINS-1:0] oe_q;
  logic            show_debug;

  assign show_debug = cap_done && (mode == MODE_BUSDBG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      oe_q   <= '0;
    end else begin
      oe_q   <= {PINS{cap_done}};
      data_q <= show_debug ? dbg_in : '0;
    end
  end

  assign pad_out = data_q;
  assign pad_oe  = oe_q;

  assert_oe_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_done |=> (pad_oe == '0))
    else $error("pins driven during strap sampling");

  assert_oe_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> (pad_oe == '1))
    else $error("pins not driven after capture");

  assert_quiet_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && mode == MODE_QUIET) |=> (pad_out == '0))
    else $error("quiet mode toggled a pin");

  assert_debug_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    show_debug |=> (pad_out == $past(dbg_in)))
    else $error("debug pin data wrong");

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_pins_off_R1: assert (pad_oe == '0 && pad_out == '0)
        else $error("pins active in reset");
    end
  end

endmodule

// File: rtl/strap_test_port.sv
module strap_test_port
  import strap_port_pkg::*;
#(
  parameter int PINS    = 8,
  parameter int SEL_BIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pad_in,
  input  logic [PINS-1:0] dbg_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] mode_status
);

  port_mode_e mode;
  logic       cap_done;

  strap_capture #(.PINS(PINS), .SEL_BIT(SEL_BIT)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_in    (pad_in),
    .mode_word (mode_status),
    .mode      (mode),
    .cap_done  (cap_done)
  );

  strap_out_stage #(.PINS(PINS)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_done (cap_done),
    .mode     (mode),
    .dbg_in   (dbg_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

endmodule

// File: tb/strap_test_port_test.sv
module strap_test_port_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] strap_lvl;
  logic [7:0] dbg_in;
  logic [7:0] pad_in;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic [7:0] mode_status;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  // Pad model: strap or pulldown level while undriven, else own output.
  always_comb begin
    for (int i = 0; i < 8; i++)
      pad_in[i] = pad_oe[i] ? pad_out[i] : strap_lvl[i];
  end

  strap_test_port uut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .dbg_in(dbg_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .mode_status(mode_status)
  );

  // Each entry is {strap, first debug word, second debug word}.
  localparam logic [23:0] VECS [6] = '{
    24'h00_A5_5A, 24'h01_A5_5A, 24'hFE_FF_0F,
    24'hFF_3C_C3, 24'h80_FF_01, 24'h81_00_FF
  };

  function automatic logic [7:0] want_pins(input logic [7:0] strap, input logic [7:0] dbg);
    if (strap[0] == 1'b1) return dbg;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic enter_reset(input logic [7:0] lvl);
    @(negedge clk);
    rst_n     = 1'b0;
    strap_lvl = lvl;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_vec(input logic [23:0] v, input string tag);
    logic [7:0] s, d0, d1;
    s = v[23:16]; d0 = v[15:8]; d1 = v[7:0];
    enter_reset(s);
    chk({"R1 oe in reset ", tag}, pad_oe, 8'h00);
    chk({"R1 status in reset ", tag}, mode_status, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);  // storing edge has passed
    chk({"R2 stored word ", tag}, mode_status, s);
    chk({"R7 oe off at store ", tag}, pad_oe, 8'h00);
    dbg_in = d0;
    @(negedge clk);
    chk({"R7 oe on ", tag}, pad_oe, 8'hFF);
    chk({"R5/R6/R8 pins first ", tag}, pad_out, want_pins(s, d0));
    dbg_in = d1;
    @(negedge clk);
    chk({"R6 latency second ", tag}, pad_out, want_pins(s, d1));
    strap_lvl = ~s;
    dbg_in    = ~d1;
    repeat (3) @(negedge clk);
    chk({"R3 word frozen ", tag}, mode_status, s);
    chk({"R5/R6 pins third ", tag}, pad_out, want_pins(s, ~d1));
  endtask

  initial begin
    rst_n     = 1'b0;
    strap_lvl = 8'h00;
    dbg_in    = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 initial oe", pad_oe, 8'h00);
    chk("R1 initial out", pad_out, 8'h00);
    chk("R1 initial status", mode_status, 8'h00);

    // Walk the vector table.
    for (int k = 0; k < 6; k++) run_vec(VECS[k], $sformatf("v%0d", k));

    // R4: pulldown only, debug lines busy.
    enter_reset(8'h00);
    dbg_in = 8'hFF;
    rst_n  = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 default word", mode_status, 8'h00);
    chk("R4 default quiet", pad_out, 8'h00);

    // R9: debug mode, then reset between edges clears without a clock.
    enter_reset(8'h01);
    rst_n  = 1'b1;
    dbg_in = 8'h96;
    repeat (3) @(negedge clk);
    chk("R9 debug before abort", pad_out, 8'h96);
    #5;
    rst_n = 1'b0;
    #1;
    chk("R1 R9 async oe clear", pad_oe, 8'h00);
    chk("R1 R9 async status clear", mode_status, 8'h00);
    strap_lvl = 8'h7E;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 fresh word", mode_status, 8'h7E);
    chk("R9 fresh quiet", pad_out, 8'h00);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule